// File: doc/BRIEF.md
# GPIO Bank Pin Interrupt Controller

This block watches the levels of one bank of 32 general-purpose pins and turns selected level or edge conditions into a single interrupt request for a parent interrupt controller. Software reaches it over a simple register bus with a 12-bit byte address, 32-bit write data, a write strobe, a read strobe and 32-bit read data. Each pin has a 3-bit trigger code, a detect-enable bit that allows its sticky pending flag to be set, and an interrupt-enable bit that lets a pending flag drive the request. The bank also stores output-enable and alternate-function settings for the pad logic outside.

Pin levels pass through a two-flop synchronizer. Edges are found by comparing the synchronized level with its copy from the previous cycle. A pending flag stays set until software writes a one to it. If a detection and a clear hit the same flag in the same cycle, the detection wins. A level trigger therefore keeps its flag set for as long as the level holds.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads as zero and `irqOut` is low.
- R2: The output enable (0x04), interrupt enable (0x10), detect enable (0x3C) and alternate function words (0x20, 0x24) read back what was last written. A read of any unmapped address returns zero. Read data appears on the clock edge that samples the read strobe.
- R3: Bit n of every per-pin word belongs to pin n. The two low bits of pin p's trigger code sit at bits (p mod 16)*2 +1:+0 of the word at 0x08 + (p/16)*4. The high bit sits at bit p of 0x28. Codes: 0 low level, 1 high level, 2 falling edge, 3 rising edge, 4 both edges.
- R4: With code 0 or 1 and detect enable set, the pending flag is set while the pin holds the active level. A pin change made between clock edges is visible in status from the third following rising edge.
- R5: Code 3 sets pending only on a 0-to-1 pin transition, and code 2 only on a 1-to-0 transition.
- R6: Code 4 sets pending on every transition in either direction.
- R7: Codes 5, 6 and 7 never set pending, whatever the pin does.
- R8: A pending flag is never set while its detect-enable bit is 0. An edge seen while detect is off is not remembered.
- R9: Writing status (0x14) clears each pending flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. No flag clears without such a write.
- R10: When a detection and a clear of the same flag occur in the same cycle, the flag stays set.
- R11: `irqOut` is high exactly when some pending flag has its interrupt-enable bit set.
- R12: A status read returns the raw pending flags, including those whose interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte address |
| busWdata | input | 32 | Write data |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, registered |
| pinIn | input | 32 | Pin levels, asynchronous |
| irqOut | output | 1 | Interrupt request to the parent controller |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a detection of the same flag. A single-cycle edge is hard to place on that cycle. The stimulus holds a pin at its active level under a level trigger, so a detection occurs in every cycle, and then issues the clear. It also drives edges with detect enable off and turns detect on afterwards, which shows that no stale edge is recorded.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PINS       = 32;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int FIELD_W    = 2;
  localparam int PINS_PER_W = DATA_W / FIELD_W;
  localparam int PACK_WORDS = PINS / PINS_PER_W;
  localparam int IDX_W      = (PACK_WORDS > 1) ? $clog2(PACK_WORDS) : 1;

  localparam logic [ADDR_W-1:0] OFS_OE      = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_MODE_LO = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_INT_EN  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ALT     = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_MODE_HI = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_DET_EN  = 12'h03C;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OE, SEL_MODE_LO, SEL_INT_EN,
    SEL_STATUS, SEL_ALT, SEL_MODE_HI, SEL_DET_EN
  } rdSel_e;

  typedef struct packed {
    logic                  wrOe;
    logic [PACK_WORDS-1:0] wrModeLo;
    logic                  wrIntEn;
    logic                  wrStatus;
    logic [PACK_WORDS-1:0] wrAlt;
    logic                  wrModeHi;
    logic                  wrDetEn;
    logic                  rdEn;
    rdSel_e                rdSel;
    logic [IDX_W-1:0]      rdIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output ctrlStrobe_t       strobe
);
  rdSel_e           sel;
  logic [IDX_W-1:0] idx;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    case (busAddr)
      OFS_OE:      sel = SEL_OE;
      OFS_INT_EN:  sel = SEL_INT_EN;
      OFS_STATUS:  sel = SEL_STATUS;
      OFS_MODE_HI: sel = SEL_MODE_HI;
      OFS_DET_EN:  sel = SEL_DET_EN;
      default:     sel = SEL_NONE;
    endcase
    for (int k = 0; k < PACK_WORDS; k++) begin
      if (busAddr == OFS_MODE_LO + ADDR_W'(4 * k)) begin
        sel = SEL_MODE_LO;
        idx = IDX_W'(k);
      end
      if (busAddr == OFS_ALT + ADDR_W'(4 * k)) begin
        sel = SEL_ALT;
        idx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrOe     = busWrite && (sel == SEL_OE);
    strobe.wrIntEn  = busWrite && (sel == SEL_INT_EN);
    strobe.wrStatus = busWrite && (sel == SEL_STATUS);
    strobe.wrModeHi = busWrite && (sel == SEL_MODE_HI);
    strobe.wrDetEn  = busWrite && (sel == SEL_DET_EN);
    for (int k = 0; k < PACK_WORDS; k++) begin
      strobe.wrModeLo[k] = busWrite && (sel == SEL_MODE_LO) && (idx == IDX_W'(k));
      strobe.wrAlt[k]    = busWrite && (sel == SEL_ALT) && (idx == IDX_W'(k));
    end
    strobe.rdEn  = busRead;
    strobe.rdSel = sel;
    strobe.rdIdx = idx;
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [PINS-1:0]   pendBits,
  output logic [PINS-1:0]   detEnBits,
  output logic [PINS-1:0]   intEnBits
);
  logic [PINS-1:0]   oeReg, intEnReg, detEnReg, modeHiReg, pendReg;
  logic [DATA_W-1:0] modeLoReg [PACK_WORDS];
  logic [DATA_W-1:0] altReg    [PACK_WORDS];
  logic [PINS-1:0]   syncA, syncB, prevLvl;
  logic [PINS-1:0]   hit;
  logic [DATA_W-1:0] clearMask;
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    localparam int WORD = i / PINS_PER_W;
    localparam int POS  = (i % PINS_PER_W) * FIELD_W;
    logic [2:0] code;
    assign code = {modeHiReg[i], modeLoReg[WORD][POS +: FIELD_W]};
    always_comb begin
      case (code)
        TRIG_LOW:  hit[i] = !syncB[i];
        TRIG_HIGH: hit[i] = syncB[i];
        TRIG_FALL: hit[i] = prevLvl[i] && !syncB[i];
        TRIG_RISE: hit[i] = !prevLvl[i] && syncB[i];
        TRIG_BOTH: hit[i] = prevLvl[i] ^ syncB[i];
        default:   hit[i] = 1'b0;
      endcase
    end
  end

  assign clearMask = strobe.wrStatus ? busWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeReg     <= '0;
      intEnReg  <= '0;
      detEnReg  <= '0;
      modeHiReg <= '0;
      pendReg   <= '0;
    end else begin
      if (strobe.wrOe)     oeReg     <= busWdata;
      if (strobe.wrIntEn)  intEnReg  <= busWdata;
      if (strobe.wrDetEn)  detEnReg  <= busWdata;
      if (strobe.wrModeHi) modeHiReg <= busWdata;
      pendReg <= (pendReg & ~clearMask) | (hit & detEnReg);
    end
  end

  for (genvar k = 0; k < PACK_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeLoReg[k] <= '0;
        altReg[k]    <= '0;
      end else begin
        if (strobe.wrModeLo[k]) modeLoReg[k] <= busWdata;
        if (strobe.wrAlt[k])    altReg[k]    <= busWdata;
      end
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_OE:      rdMux = oeReg;
      SEL_MODE_LO: rdMux = modeLoReg[strobe.rdIdx];
      SEL_INT_EN:  rdMux = intEnReg;
      SEL_STATUS:  rdMux = pendReg;
      SEL_ALT:     rdMux = altReg[strobe.rdIdx];
      SEL_MODE_HI: rdMux = modeHiReg;
      SEL_DET_EN:  rdMux = detEnReg;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdMux;
  end

  assign irqOut    = |(pendReg & intEnReg);
  assign pendBits  = pendReg;
  assign detEnBits = detEnReg;
  assign intEnBits = intEnReg;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWrite,
  input  logic              busRead,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic              irqOut
);
  ctrlStrobe_t     strobe;
  logic [PINS-1:0] pendBits, detEnBits, intEnBits;

  gpio_irq_ctrl i_ctrl (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .busRead (busRead),
    .strobe  (strobe)
  );

  gpio_irq_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .pendBits (pendBits),
    .detEnBits(detEnBits),
    .intEnBits(intEnBits)
  );
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk
  import gpio_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWrite,
  input logic              irqOut,
  input logic [PINS-1:0]   pendBits,
  input logic [PINS-1:0]   detEnBits,
  input logic [PINS-1:0]   intEnBits
);
  logic stWrite;
  assign stWrite = busWrite && (busAddr == OFS_STATUS);

  // R8: a flag that newly rises had detect enabled in the cycle before
  p_pend_needs_det_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendBits & ~$past(pendBits) & ~$past(detEnBits)) == '0));

  // R9: a clear write removes the selected flags unless a detection may win
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    stWrite |=> ((pendBits & $past(busWdata) & ~$past(detEnBits)) == '0));

  // R9: without a clear write no flag falls
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stWrite |=> ((~pendBits & $past(pendBits)) == '0));

  // R11: a request needs an enabled pending flag
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((pendBits & intEnBits) != '0));

  // R11: no flags means no request
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits == '0) |-> !irqOut);
endmodule

bind gpio_bank_irq gpio_bank_irq_chk i_chk (.*);

// File: tb/test_gpio_bank_irq.sv
module test_gpio_bank_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] pins = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] modeLo [2];
  logic [31:0] modeHi = '0;
  logic [31:0] detMask = '0;

  gpio_bank_irq i_gpio_bank_irq (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .busRead(busRead), .busRdata(busRdata),
    .pinIn(pins), .irqOut(irqOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata;
  endtask

  task automatic expectStatus(string req, logic [31:0] exp);
    logic [31:0] v;
    busRd(12'h014, v);
    check(req, v, exp);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setMode(int pin, logic [2:0] code);
    modeLo[pin / 16][(pin % 16) * 2 +: 2] = code[1:0];
    modeHi[pin] = code[2];
    busWr(12'h008 + 12'(4 * (pin / 16)), modeLo[pin / 16]);
    busWr(12'h028, modeHi);
  endtask

  task automatic setDet(int pin, logic on);
    detMask[pin] = on;
    busWr(12'h03C, detMask);
  endtask

  task automatic setPin(int pin, logic val);
    @(negedge clk);
    pins[pin] = val;
    settle();
  endtask

  task automatic t_reset();
    logic [11:0] offs [9] = '{12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                              12'h020, 12'h024, 12'h028, 12'h03C};
    logic [31:0] v;
    for (int i = 0; i < 9; i++) begin
      busRd(offs[i], v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_storage();
    logic [31:0] v;
    busWr(12'h004, 32'hA5A5_0F0F); busRd(12'h004, v); check("R2 oe", v, 32'hA5A5_0F0F);
    busWr(12'h020, 32'h1234_5678); busRd(12'h020, v); check("R2 alt0", v, 32'h1234_5678);
    busWr(12'h024, 32'h8765_4321); busRd(12'h024, v); check("R2 alt1", v, 32'h8765_4321);
    busWr(12'h010, 32'hF000_000F); busRd(12'h010, v); check("R2 inten", v, 32'hF000_000F);
    busWr(12'h010, 32'h0);
    busWr(12'h03C, 32'h00FF_0000); busRd(12'h03C, v); check("R2 deten", v, 32'h00FF_0000);
    busWr(12'h03C, 32'h0);
    busWr(12'h014, 32'hFFFF_FFFF);
    expectStatus("R9 clear all", 32'h0);
    busRd(12'h030, v); check("R2 unmapped 030", v, 32'h0);
    busRd(12'h018, v); check("R2 unmapped 018", v, 32'h0);
  endtask

  task automatic t_modeFields();
    logic [31:0] v;
    setMode(5, 3'd3); setMode(20, 3'd4); setMode(31, 3'd7);
    busRd(12'h008, v); check("R3 mode low word 0", v, 32'h0000_0C00);
    busRd(12'h00C, v); check("R3 mode low word 1", v, 32'hC000_0000);
    busRd(12'h028, v); check("R3 mode high word", v, 32'h8010_0000);
    setMode(5, 3'd0); setMode(20, 3'd0); setMode(31, 3'd0);
  endtask

  task automatic t_level();
    setMode(3, 3'd1); setDet(3, 1'b1);
    settle();
    expectStatus("R4 high level idle", 32'h0);
    setPin(3, 1'b1);
    expectStatus("R4 high level pend", 32'h0000_0008);
    busWr(12'h014, 32'h0000_0008);
    expectStatus("R10 detection beats clear", 32'h0000_0008);
    setPin(3, 1'b0);
    busWr(12'h014, 32'h0000_0008);
    expectStatus("R4 released level clears", 32'h0);
    setDet(3, 1'b0);
  endtask

  task automatic t_lowLevel();
    setMode(4, 3'd0); setDet(4, 1'b1);
    settle();
    expectStatus("R4 low level pend", 32'h0000_0010);
    setDet(4, 1'b0);
    busWr(12'h014, 32'h0000_0010);
    settle();
    expectStatus("R8 no pend with detect off", 32'h0);
  endtask

  task automatic t_rise();
    setMode(8, 3'd3); setDet(8, 1'b1);
    setPin(8, 1'b1);
    expectStatus("R5 rising edge pend", 32'h0000_0100);
    busWr(12'h014, 32'h0000_0100);
    expectStatus("R9 clear rising", 32'h0);
    setPin(8, 1'b0);
    expectStatus("R5 falling ignored by rise code", 32'h0);
  endtask

  task automatic t_fall();
    setMode(9, 3'd2); setDet(9, 1'b1);
    setPin(9, 1'b1);
    expectStatus("R5 rising ignored by fall code", 32'h0);
    setPin(9, 1'b0);
    expectStatus("R5 falling edge pend", 32'h0000_0200);
    busWr(12'h014, 32'h0000_0200);
    setDet(9, 1'b0);
  endtask

  task automatic t_both();
    setMode(10, 3'd4); setDet(10, 1'b1);
    setPin(10, 1'b1);
    expectStatus("R6 both code on rise", 32'h0000_0400);
    busWr(12'h014, 32'h0000_0400);
    setPin(10, 1'b0);
    expectStatus("R6 both code on fall", 32'h0000_0400);
    busWr(12'h014, 32'h0000_0400);
    expectStatus("R6 cleared", 32'h0);
  endtask

  task automatic t_badCodes();
    setMode(11, 3'd5); setMode(12, 3'd6); setMode(13, 3'd7);
    setDet(11, 1'b1); setDet(12, 1'b1); setDet(13, 1'b1);
    settle();
    expectStatus("R7 idle low", 32'h0);
    @(negedge clk); pins[13:11] = 3'b111; settle();
    expectStatus("R7 after rise", 32'h0);
    @(negedge clk); pins[13:11] = 3'b000; settle();
    expectStatus("R7 after fall", 32'h0);
    setDet(11, 1'b0); setDet(12, 1'b0); setDet(13, 1'b0);
  endtask

  task automatic t_detOff();
    setMode(14, 3'd3);
    setPin(14, 1'b1);
    expectStatus("R8 edge with detect off", 32'h0);
    setDet(14, 1'b1);
    settle();
    expectStatus("R8 stale edge not kept", 32'h0);
    setDet(14, 1'b0);
    setPin(14, 1'b0);
  endtask

  task automatic t_partialIrq();
    @(negedge clk); pins[8] = 1'b1; pins[10] = 1'b1; settle();
    expectStatus("R9 two pending", 32'h0000_0500);
    busWr(12'h014, 32'h0000_0100);
    expectStatus("R9 zero bits untouched", 32'h0000_0400);
    busWr(12'h010, 32'h0000_0001);
    check("R11 irq low when pending masked", {31'b0, irqOut}, 32'h0);
    expectStatus("R12 raw status under mask", 32'h0000_0400);
    busWr(12'h010, 32'h0000_0400);
    check("R11 irq high when enabled", {31'b0, irqOut}, 32'h1);
    busWr(12'h014, 32'h0000_0400);
    check("R11 irq low after clear", {31'b0, irqOut}, 32'h0);
  endtask

  logic done = 1'b0;

  initial begin
    modeLo[0] = '0; modeLo[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_storage();
    t_modeFields();
    t_level();
    t_lowLevel();
    t_rise();
    t_fall();
    t_both();
    t_badCodes();
    t_detOff();
    t_partialIrq();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule